// File: doc/BRIEF.md
# ADC Conversion Sequencer with Auto-Scan

This block is the digital side of a successive-approximation converter. Software reaches it through a small register port: a status/control register, a clock register, a high-bits register and four result registers. A write to the status/control register starts a conversion. The block then drives the channel number to the analog front end and times the conversion on a derived conversion clock. When the conversion ends, it stores the result and raises a completion flag. The conversion clock is an enable strobe. It comes from the bus clock or from an oscillator strobe, and then passes through a power-of-two prescaler.

Three operating patterns are supported. A single conversion converts one channel once. Continuous conversion repeats on one channel until software turns the repeat bit off. Auto-scan uses a 2-bit counter that walks the channels from 0 up to a programmable last channel. The counter value selects both the channel and the result register. Scanning stops at the last channel until the next control write. A behavioural stub stands in for the analog converter and returns a fixed function of the channel.

Top module: `adc_seq`

## Requirements
- R1: After reset every readable register is zero, `busy_o` is low and `chan_o` is zero.
- R2: Clock register bit 0 selects the tick source: 0 is the bus clock (every cycle) and 1 is `osc_tick_i` pulses. Bits 3:1 give the prescale code: codes 0 to 4 divide by 1, 2, 4, 8 and 16, and codes 5 to 7 divide by 16. With ratio d, the flag becomes visible between 16d+1 and 17d source ticks after the control write edge.
- R3: Every conversion lasts exactly 16 conversion ticks after the tick that starts it.
- R4: The stub sample is {channel, ~channel} (10 bits). Clock register bit 6 selects the result mode. With bit 6 at 0, result register 0 (address 3) gets sample[9:2] and the high register (address 2) gets 0. With bit 6 at 1, result 0 gets sample[7:0] and the high register gets sample[9:8].
- R5: Status/control bit 5 set gives continuous conversion. Each new result overwrites result 0 in the result mode in force at that moment, whether or not the old result was read.
- R6: Status/control bit 7 is the completion flag. It is set by every conversion end. It is cleared by any status/control write or by a read of address 3.
- R7: Status/control bit 6 set gives auto-scan. A control write resets the scan counter. Channel k goes to result register k (addresses 3 to 6), always in truncated form, whatever bit 6 of the clock register holds.
- R8: The scan runs from channel 0 to the last-channel field (clock register bits 5:4) and then stops, with `chan_o` holding that last channel. It takes 16 x (last+1) ticks.
- R9: A status/control write with bits 5 and 6 clear, made during a conversion, lets that conversion finish and store its result. No further conversion starts.
- R10: `chan_o` shows the channel field (bits 4:0) of the status/control register, or the scan counter in auto-scan, and holds the active channel during a conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| osc_tick_i | input | 1 | Oscillator strobe, synchronous to clk_i |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (used for the read-clear side effect) |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, combinational on addr_i |
| chan_o | output | 5 | Channel select to the analog front end |
| busy_o | output | 1 | A conversion is in progress |

## Verification
The bench uses the default parameters: 5-bit channels, a 2-bit scan counter, a 3-bit prescale code and 16-tick conversions. The 3-bit code reaches the clamp codes above divide-by-16, and the 2-bit counter reaches all four result registers. The oscillator strobe fires every third cycle. This separates tick counts from cycle counts, so the latency window is checked against ticks and not against bus cycles.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_SC   = 3'd0,
    A_CK   = 3'd1,
    A_HI   = 3'd2,
    A_R0   = 3'd3,
    A_R1   = 3'd4,
    A_R2   = 3'd5,
    A_R3   = 3'd6,
    A_NONE = 3'd7
  } addr_e;

  typedef enum logic {
    RM_TRUNC = 1'b0,
    RM_WIDE  = 1'b1
  } rmode_e;
endpackage

// File: rtl/adc_clkgen.sv
`timescale 1ns/1ps
module adc_clkgen #(
  parameter int CODE_W = 3,
  parameter int CNT_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              src_sel_i,
  input  logic              osc_tick_i,
  input  logic [CODE_W-1:0] div_code_i,
  output logic              tick_o
);
  localparam int MAX_CODE = CNT_W;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;
  logic             src_pulse;

  always_comb begin
    src_pulse = src_sel_i ? osc_tick_i : 1'b1;
    lim = '1;
    if (int'(div_code_i) < MAX_CODE) lim = CNT_W'((32'd1 << div_code_i) - 32'd1);
    tick_o = src_pulse && (cnt_q == lim);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (clr_i)     cnt_q <= '0;
    else if (src_pulse) cnt_q <= tick_o ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/adc_stub.sv
`timescale 1ns/1ps
module adc_stub #(
  parameter int CHAN_W = 5
) (
  input  logic [CHAN_W-1:0]   chan_i,
  output logic [2*CHAN_W-1:0] sample_o
);
  // behavioural stand-in for the analog converter
  assign sample_o = {chan_i, ~chan_i};
endmodule

// File: rtl/adc_ctrl.sv
`timescale 1ns/1ps
module adc_ctrl #(
  parameter int CHAN_W   = 5,
  parameter int SLOT_W   = 2,
  parameter int CONV_LEN = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              sc_wr_i,
  input  logic              wr_cont_i,
  input  logic              wr_scan_i,
  input  logic              cont_i,
  input  logic              scan_i,
  input  logic [CHAN_W-1:0] chan_i,
  input  logic [SLOT_W-1:0] last_i,
  output logic              busy_o,
  output logic              fin_o,
  output logic              pend_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              scan_cur_o,
  output logic [CHAN_W-1:0] chan_o
);
  localparam int PH_W = $clog2(CONV_LEN);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(CONV_LEN - 1);

  logic              busy_q, pend_q, cur_scan_q;
  logic [PH_W-1:0]   ph_q;
  logic [SLOT_W-1:0] cnt_q, cur_slot_q;
  logic [CHAN_W-1:0] cur_chan_q, sel_chan;
  logic              fin, pend_set, take, scan_more;

  always_comb begin
    fin       = busy_q && tick_i && (ph_q == PH_LAST);
    pend_set  = sc_wr_i && (!busy_q || wr_cont_i || wr_scan_i);
    take      = tick_i && pend_q && (!busy_q || (fin && !sc_wr_i));
    scan_more = scan_i && cur_scan_q && (cnt_q != last_i);
    sel_chan  = scan_i ? CHAN_W'(cnt_q) : chan_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      pend_q     <= 1'b0;
      ph_q       <= '0;
      cnt_q      <= '0;
      cur_slot_q <= '0;
      cur_chan_q <= '0;
      cur_scan_q <= 1'b0;
    end else begin
      pend_q <= pend_set || (pend_q && !take);
      if (sc_wr_i && wr_scan_i) cnt_q <= '0;
      if (busy_q && tick_i && !fin) ph_q <= ph_q + 1'b1;
      if (take) begin
        busy_q     <= 1'b1;
        ph_q       <= '0;
        cur_chan_q <= sel_chan;
        cur_slot_q <= scan_i ? cnt_q : '0;
        cur_scan_q <= scan_i;
      end else if (fin) begin
        ph_q <= '0;
        if (sc_wr_i) begin
          busy_q <= 1'b0;  // a fresh start is queued by the write
        end else if (scan_more) begin
          cnt_q      <= cnt_q + 1'b1;
          cur_slot_q <= cnt_q + 1'b1;
          cur_chan_q <= CHAN_W'(cnt_q + 1'b1);
        end else if (cont_i && !scan_i) begin
          cur_chan_q <= chan_i;
          cur_slot_q <= '0;
          cur_scan_q <= 1'b0;
        end else begin
          busy_q <= 1'b0;
        end
      end
    end
  end

  assign busy_o     = busy_q;
  assign fin_o      = fin;
  assign pend_o     = pend_q;
  assign slot_o     = cur_slot_q;
  assign scan_cur_o = cur_scan_q;
  assign chan_o     = busy_q ? cur_chan_q : sel_chan;
endmodule

// File: rtl/adc_seq.sv
`timescale 1ns/1ps
module adc_seq import adc_seq_pkg::*; #(
  parameter int CHAN_W    = 5,
  parameter int SLOT_W    = 2,
  parameter int CODE_W    = 3,
  parameter int DIV_CNT_W = 4,
  parameter int CONV_LEN  = 16,
  parameter int DATA_W    = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              osc_tick_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [CHAN_W-1:0] chan_o,
  output logic              busy_o
);
  localparam int SMP_W    = 2 * CHAN_W;
  localparam int NUM_RES  = 1 << SLOT_W;
  localparam int HI_W     = SMP_W - DATA_W;
  localparam int CONT_B   = CHAN_W;
  localparam int SCAN_B   = CHAN_W + 1;
  localparam int FLAG_B   = DATA_W - 1;
  localparam int SRC_B    = 0;
  localparam int DIV_LSB  = 1;
  localparam int LAST_LSB = DIV_LSB + CODE_W;
  localparam int MODE_B   = LAST_LSB + SLOT_W;

  logic [CHAN_W-1:0] chan_q;
  logic              cont_q, scan_q, coco_q;
  logic              src_q;
  logic [CODE_W-1:0] div_q;
  logic [SLOT_W-1:0] last_q;
  rmode_e            mode_q;
  logic [HI_W-1:0]   hi_q;

  logic              sc_wr, ck_wr, r0_rd;
  logic              tick, busy, fin, pend, cur_scan;
  logic [SLOT_W-1:0] slot;
  logic [SMP_W-1:0]  sample;
  logic [DATA_W-1:0] store_val;
  logic [NUM_RES-1:0][DATA_W-1:0] res_all;

  assign sc_wr = wr_en_i && (addr_i == A_SC);
  assign ck_wr = wr_en_i && (addr_i == A_CK);
  assign r0_rd = rd_en_i && (addr_i == A_R0);

  adc_clkgen #(.CODE_W(CODE_W), .CNT_W(DIV_CNT_W)) u_clkgen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (ck_wr),
    .src_sel_i  (src_q),
    .osc_tick_i (osc_tick_i),
    .div_code_i (div_q),
    .tick_o     (tick)
  );

  adc_ctrl #(.CHAN_W(CHAN_W), .SLOT_W(SLOT_W), .CONV_LEN(CONV_LEN)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tick_i     (tick),
    .sc_wr_i    (sc_wr),
    .wr_cont_i  (wdata_i[CONT_B]),
    .wr_scan_i  (wdata_i[SCAN_B]),
    .cont_i     (cont_q),
    .scan_i     (scan_q),
    .chan_i     (chan_q),
    .last_i     (last_q),
    .busy_o     (busy),
    .fin_o      (fin),
    .pend_o     (pend),
    .slot_o     (slot),
    .scan_cur_o (cur_scan),
    .chan_o     (chan_o)
  );

  adc_stub #(.CHAN_W(CHAN_W)) u_stub (
    .chan_i   (chan_o),
    .sample_o (sample)
  );

  // scan results are always truncated
  assign store_val = (cur_scan || mode_q == RM_TRUNC) ? sample[SMP_W-1 -: DATA_W]
                                                      : sample[DATA_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chan_q <= '0;
      cont_q <= 1'b0;
      scan_q <= 1'b0;
      coco_q <= 1'b0;
      src_q  <= 1'b0;
      div_q  <= '0;
      last_q <= '0;
      mode_q <= RM_TRUNC;
      hi_q   <= '0;
    end else begin
      if (sc_wr) begin
        chan_q <= wdata_i[CHAN_W-1:0];
        cont_q <= wdata_i[CONT_B];
        scan_q <= wdata_i[SCAN_B];
      end
      if (ck_wr) begin
        src_q  <= wdata_i[SRC_B];
        div_q  <= wdata_i[DIV_LSB +: CODE_W];
        last_q <= wdata_i[LAST_LSB +: SLOT_W];
        mode_q <= rmode_e'(wdata_i[MODE_B]);
      end
      if (fin)                 coco_q <= 1'b1;
      else if (sc_wr || r0_rd) coco_q <= 1'b0;
      if (fin && !cur_scan)
        hi_q <= (mode_q == RM_WIDE) ? sample[SMP_W-1 -: HI_W] : '0;
    end
  end

  for (genvar g = 0; g < NUM_RES; g++) begin : g_res
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          q <= '0;
      else if (fin && slot == SLOT_W'(g))  q <= store_val;
    end
    assign res_all[g] = q;
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_SC: begin
        rdata_o[CHAN_W-1:0] = chan_q;
        rdata_o[CONT_B]     = cont_q;
        rdata_o[SCAN_B]     = scan_q;
        rdata_o[FLAG_B]     = coco_q;
      end
      A_CK: begin
        rdata_o[SRC_B]                 = src_q;
        rdata_o[DIV_LSB +: CODE_W]     = div_q;
        rdata_o[LAST_LSB +: SLOT_W]    = last_q;
        rdata_o[MODE_B]                = mode_q;
      end
      A_HI: rdata_o[HI_W-1:0] = hi_q;
      A_R0, A_R1, A_R2, A_R3: rdata_o = res_all[SLOT_W'(addr_i - A_R0)];
      default: rdata_o = '0;
    endcase
  end

  assign busy_o = busy;
endmodule

// File: rtl/adc_seq_chk.sv
`timescale 1ns/1ps
module adc_seq_chk #(
  parameter int CONV_LEN = 16,
  parameter int SLOT_W   = 2,
  parameter int CHAN_W   = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              busy_i,
  input logic              fin_i,
  input logic              pend_i,
  input logic              sc_wr_i,
  input logic              r0_rd_i,
  input logic              coco_i,
  input logic              scan_cur_i,
  input logic              scan_i,
  input logic [SLOT_W-1:0] slot_i,
  input logic [SLOT_W-1:0] last_i,
  input logic [CHAN_W-1:0] chan_i
);
  localparam int TW = $clog2(CONV_LEN) + 1;
  logic [TW-1:0] tk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              tk_q <= '0;
    else if (fin_i || !busy_i) tk_q <= '0;
    else if (tick_i)          tk_q <= tk_q + 1'b1;
  end

  AST_START_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_i) |-> $past(tick_i)); // R2
  AST_CONV_LEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_i |-> tk_q == TW'(CONV_LEN - 1)); // R3
  AST_DONE_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_i |=> coco_i); // R6
  AST_RD_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (r0_rd_i && !fin_i) |=> !coco_i); // R6
  AST_SCAN_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin_i && scan_cur_i) |-> chan_i == CHAN_W'(slot_i)); // R7
  AST_SCAN_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fin_i && scan_cur_i && scan_i && !pend_i && !sc_wr_i && slot_i == last_i) |=> !busy_i); // R8
endmodule

bind adc_seq adc_seq_chk #(.CONV_LEN(CONV_LEN), .SLOT_W(SLOT_W), .CHAN_W(CHAN_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick_i     (tick),
  .busy_i     (busy),
  .fin_i      (fin),
  .pend_i     (pend),
  .sc_wr_i    (sc_wr),
  .r0_rd_i    (r0_rd),
  .coco_i     (coco_q),
  .scan_cur_i (cur_scan),
  .scan_i     (scan_q),
  .slot_i     (slot),
  .last_i     (last_q),
  .chan_i     (chan_o)
);

// File: tb/sim_adc_seq.sv
`timescale 1ns/1ps
module sim_adc_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       osc_tick = 1'b0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic [4:0] chan;
  logic       busy;
  int n_chk = 0, n_err = 0, osc_edges = 0, osc_ph = 0;

  always #10 clk = ~clk;

  adc_seq u0 (
    .clk_i(clk), .rst_ni(rst_n), .osc_tick_i(osc_tick),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .chan_o(chan), .busy_o(busy)
  );

  always @(negedge clk) begin
    osc_ph = (osc_ph == 2) ? 0 : osc_ph + 1;
    osc_tick = (osc_ph == 2);
  end
  always @(posedge clk) if (osc_tick) osc_edges++;

  function automatic logic [9:0] samp(input logic [4:0] c);
    return {c, ~c};
  endfunction
  function automatic int ratio(input logic [2:0] code);
    return (code > 3'd4) ? 16 : (1 << code);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask
  task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
    n_chk++;
    if (act < lo || act > hi) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d..%0d", tag, act, lo, hi);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask
  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask
  task automatic peek(input logic [2:0] a, output logic [7:0] d);
    addr = a; #1 d = rdata;
  endtask
  task automatic wait_flag(output int n);
    logic [7:0] d;
    n = 0; peek(3'd0, d);
    while (!d[7] && n < 3000) begin @(negedge clk); n++; peek(3'd0, d); end
  endtask
  task automatic wait_idle(output int n);
    n = 0;
    while (busy !== 1'b0 || n == 0) begin
      @(negedge clk); n++;
      if (n > 3000) break;
    end
  endtask

  task automatic run_single(input logic [4:0] ch, input logic [2:0] code,
                            input logic mode, input logic src);
    logic [7:0] d; int n, e0, r;
    logic [9:0] s;
    s = samp(ch); r = ratio(code);
    wr(3'd1, {1'b0, mode, 2'b00, code, src});
    wr(3'd0, {3'b000, ch});
    chk("R10 chan_o after start", 32'(chan), 32'(ch));
    e0 = osc_edges;
    wait_flag(n);
    if (src) chk_rng("R2 osc tick latency", osc_edges - e0, 16*r + 1, 17*r);
    else     chk_rng("R2 bus latency", n, 16*r + 1, 17*r);
    rd(3'd3, d);
    chk("R4 result 0", 32'(d), mode ? 32'(s[7:0]) : 32'(s[9:2]));
    peek(3'd2, d);
    chk("R4 high bits", 32'(d), mode ? 32'(s[9:8]) : 32'd0);
    peek(3'd0, d);
    chk("R6 flag cleared by result read", 32'(d[7]), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL R3 watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] d; int n;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 7; a++) begin
      peek(3'(a), d);
      chk($sformatf("R1 reg %0d reset", a), 32'(d), 32'd0);
    end
    chk("R1 busy reset", 32'(busy), 32'd0);
    chk("R1 chan reset", 32'(chan), 32'd0);

    // directed prescale and source cases
    run_single(5'h13, 3'd0, 1'b0, 1'b0);
    run_single(5'h1A, 3'd7, 1'b1, 1'b0);
    run_single(5'h05, 3'd2, 1'b0, 1'b1);

    // continuous: overwrite under new mode, then stop mid-conversion
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h3A);
    wait_flag(n);
    chk_rng("R3 first conversion length", n, 17, 17);
    rd(3'd3, d);
    chk("R5 first continuous result", 32'(d), 32'h0D1);
    wr(3'd1, 8'h40);
    wait_flag(n);
    rd(3'd3, d);
    chk("R5 overwritten in wide mode", 32'(d), 32'h045);
    peek(3'd2, d);
    chk("R5 high bits wide", 32'(d), 32'd3);
    chk("R5 still converting", 32'(busy), 32'd1);
    wr(3'd1, 8'h00);
    wr(3'd0, 8'h1A);
    chk("R9 current conversion continues", 32'(busy), 32'd1);
    wait_idle(n);
    chk_rng("R9 stops within one conversion", n, 1, 17);
    peek(3'd0, d);
    chk("R9 flag set by last conversion", 32'(d[7]), 32'd1);
    peek(3'd3, d);
    chk("R9 last result stored truncated", 32'(d), 32'h0D1);
    repeat (40) @(negedge clk);
    chk("R5 no restart after clear", 32'(busy), 32'd0);

    // auto-scan to channel 2, wide mode requested but ignored
    wr(3'd1, 8'h60);
    wr(3'd0, 8'h49);
    peek(3'd0, d);
    chk("R6 flag cleared by control write", 32'(d[7]), 32'd0);
    wait_idle(n);
    chk("R8 scan length last=2", 32'(n), 32'(16*3 + 1));
    for (int k = 0; k < 3; k++) begin
      peek(3'(3 + k), d);
      chk($sformatf("R7 scan slot %0d", k), 32'(d), 32'(samp(5'(k)) >> 2));
    end
    peek(3'd6, d);
    chk("R8 slot beyond last untouched", 32'(d), 32'd0);
    chk("R8 chan_o holds last channel", 32'(chan), 32'd2);
    repeat (40) @(negedge clk);
    chk("R8 scan halted", 32'(busy), 32'd0);
    wr(3'd1, 8'h30);
    peek(3'd0, d);
    chk("R6 clock write keeps flag", 32'(d[7]), 32'd1);
    wr(3'd0, 8'h40);
    wait_idle(n);
    chk("R8 scan length last=3", 32'(n), 32'(16*4 + 1));
    peek(3'd6, d);
    chk("R7 scan slot 3", 32'(d), 32'(samp(5'd3) >> 2));

    // scan cleared during channel 1
    wr(3'd0, 8'h40);
    repeat (18) @(negedge clk);
    wr(3'd0, 8'h00);
    wait_idle(n);
    chk_rng("R9 scan ends after channel 1", n + 20, 33, 33);
    repeat (40) @(negedge clk);
    chk("R9 no further scan", 32'(busy), 32'd0);
    chk("R10 chan_o follows field", 32'(chan), 32'd0);

    // random single conversions
    for (int i = 0; i < 16; i++) begin
      logic [4:0] ch; logic [2:0] code; logic mode, src;
      ch = 5'($urandom % 32); code = 3'($urandom % 8); mode = 1'($urandom % 2);
      src = (i % 4 == 3);
      if (src) code = 3'($urandom % 3);
      run_single(ch, code, mode, src);
    end

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule